// File: doc/BRIEF.md
# Narrow-Access Register Window Adapter

This block sits between a host port that issues 1-, 2- or 4-byte accesses into a 128-byte little-endian I/O window and three downstream register regions that only understand aligned 32-bit words: a bank of controller core registers, a bank of transfer-engine registers and a single bus/control word. It works out which region and word index an access targets. It then turns every host access into word-wide downstream operations.

A read fetches the aligned word, shifts it down by the byte offset and clears every byte above the requested size. An aligned full-word write is passed straight through. Any other write goes through read-modify-write: the block first fetches the current word, then replaces only the addressed byte lanes, and finally writes the whole word back on the next cycle. The host is held off during that sequence. Reads from holes in the window return zero, and writes to holes cause no downstream activity.

Top module: `io_window_adapter`

## Requirements
- R1: Aligned word offsets 0x00 to 0x3C select the core region, and the word index is the offset divided by 4 (4 bits).
- R2: Aligned word offsets 0x40 to 0x5C select the engine region, and the word index is (offset minus 0x40) divided by 4 (3 bits).
- R3: The aligned word at offset 0x70 selects the control register, so any byte address 0x70 to 0x73 reaches it.
- R4: Byte addresses 0x60 to 0x6F and 0x74 to 0x7F are unmapped. A read of them returns 0, and a write of any size raises no downstream read or write strobe.
- R5: A write with req_size_i of 2 or 3 (4 bytes) at an address whose two low bits are 0 produces exactly one downstream write of req_wdata_i unchanged, with no read strobe.
- R6: Any other write to a mapped word reads that word and, on the next cycle, writes the same index. Byte k of the word occupies bits 8k+7:8k. Bytes off to off+n-1 take host data bytes 0 to n-1, where n is 1, 2 or 4 for req_size_i 0, 1 or 2/3. Bytes beyond byte 3 are dropped, and all other bytes keep their old value.
- R7: A read returns the aligned word shifted right by 8 times the byte offset and masked to n bytes, zero above. A mapped read issues exactly one read strobe and no write strobe.
- R8: req_ready_o is high only when idle. A request is taken on a clock edge with req_valid_i and req_ready_o both high, and later changes on the request inputs do not affect it. Each taken request yields exactly one single-cycle rsp_valid_o, after which req_ready_o is high again. Writes answer with rsp_rdata_o equal to 0.
- R9: While reset is asserted and just after it is released: req_ready_o is 1, rsp_valid_o is 0 and all six strobes are 0.
- R10: At most one of the six downstream strobes is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Host request present |
| req_ready_o | output | 1 | Adapter idle, request taken on this edge |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 7 | Byte address in the window |
| req_size_i | input | 2 | 0 = 1 byte, 1 = 2 bytes, 2/3 = 4 bytes |
| req_wdata_i | input | 32 | Write data, least significant byte first |
| rsp_valid_o | output | 1 | Response strobe, one cycle |
| rsp_rdata_o | output | 32 | Read data aligned to bit 0 |
| core_rd_o | output | 1 | Core region read strobe |
| core_wr_o | output | 1 | Core region write strobe |
| core_idx_o | output | 4 | Core region word index |
| core_wdata_o | output | 32 | Core region write word |
| core_rdata_i | input | 32 | Core region word at core_idx_o |
| dma_rd_o | output | 1 | Engine region read strobe |
| dma_wr_o | output | 1 | Engine region write strobe |
| dma_idx_o | output | 3 | Engine region word index |
| dma_wdata_o | output | 32 | Engine region write word |
| dma_rdata_i | input | 32 | Engine region word at dma_idx_o |
| bac_rd_o | output | 1 | Control register read strobe |
| bac_wr_o | output | 1 | Control register write strobe |
| bac_wdata_o | output | 32 | Control register write word |
| bac_rdata_i | input | 32 | Control register value |

## Verification
The bench sweeps every byte address with every access size, both reading and writing, against bench-side register models. Expected words are computed by byte arithmetic.

The sweep targets several specific mistakes:
- Byte-lane placement. A mirrored lane order would corrupt neighbouring bytes.
- Accesses that run past byte 3. Wrapping would spill host bytes into the low lanes.
- The holes at 0x60 to 0x6F and above 0x73. A loose decoder would write the control word or return stale data there.
- The choice between a direct store and read-modify-write. Taking the wrong one either loses untouched bytes or adds an unneeded read strobe, and strobe counts per transaction expose both.

The request inputs are scrambled right after acceptance, so a design that does not latch the request shows up as well.

// File: rtl/win_pkg.sv
package win_pkg;

  typedef enum logic [1:0] {
    RG_NONE = 2'd0,
    RG_CORE = 2'd1,
    RG_DMA  = 2'd2,
    RG_BAC  = 2'd3
  } region_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_STORE = 2'd2,
    ST_DONE  = 2'd3
  } seq_state_e;

  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_HALF = 2'd1;

endpackage

// File: rtl/win_decode.sv
module win_decode
  import win_pkg::*;
#(
  parameter int unsigned AW         = 7,
  parameter int unsigned CORE_WORDS = 16,
  parameter int unsigned DMA_WORDS  = 8,
  parameter int unsigned BAC_OFF    = 'h70,
  parameter int unsigned CIW        = $clog2(CORE_WORDS),
  parameter int unsigned DIW        = $clog2(DMA_WORDS)
) (
  input  logic [AW-1:0]  waddr_i,
  output region_e        region_o,
  output logic [CIW-1:0] core_idx_o,
  output logic [DIW-1:0] dma_idx_o
);
  localparam int unsigned CORE_END = CORE_WORDS * 4;
  localparam int unsigned DMA_END  = CORE_END + DMA_WORDS * 4;

  logic [AW-1:0] dma_off;

  assign dma_off    = waddr_i - AW'(CORE_END);
  assign core_idx_o = CIW'(waddr_i >> 2);
  assign dma_idx_o  = DIW'(dma_off >> 2);

  always_comb begin
    if (int'(waddr_i) < CORE_END)      region_o = RG_CORE;
    else if (int'(waddr_i) < DMA_END)  region_o = RG_DMA;
    else if (int'(waddr_i) == BAC_OFF) region_o = RG_BAC;
    else                               region_o = RG_NONE;
  end

endmodule

// File: rtl/win_lanes.sv
module win_lanes
  import win_pkg::*;
#(
  parameter int unsigned DW = 32,
  parameter int unsigned NB = DW / 8,
  parameter int unsigned OW = $clog2(NB)
) (
  input  logic [OW-1:0] off_i,
  input  logic [1:0]    size_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [DW-1:0] cur_i,
  input  logic [DW-1:0] rword_i,
  output logic [DW-1:0] merged_o,
  output logic [DW-1:0] rdata_o
);
  logic [NB-1:0] lo_mask;
  logic [NB-1:0] be;
  logic [DW-1:0] wsh;
  logic [DW-1:0] rsh;

  always_comb begin
    case (size_i)
      SZ_BYTE: lo_mask = NB'(1);
      SZ_HALF: lo_mask = NB'(3);
      default: lo_mask = '1;
    endcase
  end

  // lanes shifted past the top byte fall off the word
  assign be  = lo_mask << off_i;
  assign wsh = wdata_i << {off_i, 3'b000};
  assign rsh = rword_i >> {off_i, 3'b000};

  for (genvar k = 0; k < NB; k++) begin : g_lane
    assign merged_o[8*k +: 8] = be[k] ? wsh[8*k +: 8] : cur_i[8*k +: 8];
    assign rdata_o[8*k +: 8]  = lo_mask[k] ? rsh[8*k +: 8] : 8'h00;
  end

endmodule

// File: rtl/win_seq.sv
module win_seq
  import win_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_valid_i,
  input  logic direct_store_i,
  input  logic is_write_i,
  output logic ready_o,
  output logic accept_o,
  output logic fetch_o,
  output logic store_o,
  output logic done_o
);
  seq_state_e state_q, state_d;

  assign ready_o  = (state_q == ST_IDLE);
  assign accept_o = ready_o & req_valid_i;
  assign fetch_o  = (state_q == ST_FETCH);
  assign store_o  = (state_q == ST_STORE);
  assign done_o   = (state_q == ST_DONE);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (req_valid_i) state_d = direct_store_i ? ST_STORE : ST_FETCH;
      ST_FETCH: state_d = is_write_i ? ST_STORE : ST_DONE;
      ST_STORE: state_d = ST_DONE;
      ST_DONE:  state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

endmodule

// File: rtl/io_window_adapter.sv
module io_window_adapter
  import win_pkg::*;
#(
  parameter int unsigned AW         = 7,
  parameter int unsigned DW         = 32,
  parameter int unsigned CORE_WORDS = 16,
  parameter int unsigned DMA_WORDS  = 8,
  parameter int unsigned BAC_OFF    = 'h70,
  parameter int unsigned CIW        = $clog2(CORE_WORDS),
  parameter int unsigned DIW        = $clog2(DMA_WORDS)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           req_valid_i,
  output logic           req_ready_o,
  input  logic           req_write_i,
  input  logic [AW-1:0]  req_addr_i,
  input  logic [1:0]     req_size_i,
  input  logic [DW-1:0]  req_wdata_i,
  output logic           rsp_valid_o,
  output logic [DW-1:0]  rsp_rdata_o,
  output logic           core_rd_o,
  output logic           core_wr_o,
  output logic [CIW-1:0] core_idx_o,
  output logic [DW-1:0]  core_wdata_o,
  input  logic [DW-1:0]  core_rdata_i,
  output logic           dma_rd_o,
  output logic           dma_wr_o,
  output logic [DIW-1:0] dma_idx_o,
  output logic [DW-1:0]  dma_wdata_o,
  input  logic [DW-1:0]  dma_rdata_i,
  output logic           bac_rd_o,
  output logic           bac_wr_o,
  output logic [DW-1:0]  bac_wdata_o,
  input  logic [DW-1:0]  bac_rdata_i
);
  localparam int unsigned NB = DW / 8;
  localparam int unsigned OW = $clog2(NB);

  logic          accept, fetch, store, done, direct_store;
  logic          q_wr;
  logic [AW-1:0] q_addr;
  logic [1:0]    q_size;
  logic [DW-1:0] q_wdata;
  logic [AW-1:0] waddr;
  logic [OW-1:0] off;
  region_e       region;
  logic [DW-1:0] cur_word, cur_q, merged, rd_ext, rsp_q;

  assign direct_store = req_write_i && (req_size_i >= 2'd2) &&
                        (req_addr_i[OW-1:0] == '0);

  win_seq u_seq (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .req_valid_i    (req_valid_i),
    .direct_store_i (direct_store),
    .is_write_i     (q_wr),
    .ready_o        (req_ready_o),
    .accept_o       (accept),
    .fetch_o        (fetch),
    .store_o        (store),
    .done_o         (done)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_wr    <= 1'b0;
      q_addr  <= '0;
      q_size  <= '0;
      q_wdata <= '0;
    end else if (accept) begin
      q_wr    <= req_write_i;
      q_addr  <= req_addr_i;
      q_size  <= req_size_i;
      q_wdata <= req_wdata_i;
    end
  end

  assign off   = q_addr[OW-1:0];
  assign waddr = {q_addr[AW-1:OW], {OW{1'b0}}};

  win_decode #(
    .AW(AW), .CORE_WORDS(CORE_WORDS), .DMA_WORDS(DMA_WORDS),
    .BAC_OFF(BAC_OFF), .CIW(CIW), .DIW(DIW)
  ) u_dec (
    .waddr_i    (waddr),
    .region_o   (region),
    .core_idx_o (core_idx_o),
    .dma_idx_o  (dma_idx_o)
  );

  always_comb begin
    unique case (region)
      RG_CORE: cur_word = core_rdata_i;
      RG_DMA:  cur_word = dma_rdata_i;
      RG_BAC:  cur_word = bac_rdata_i;
      default: cur_word = '0;
    endcase
  end

  win_lanes #(.DW(DW), .NB(NB), .OW(OW)) u_lanes (
    .off_i    (off),
    .size_i   (q_size),
    .wdata_i  (q_wdata),
    .cur_i    (cur_q),
    .rword_i  (cur_word),
    .merged_o (merged),
    .rdata_o  (rd_ext)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_q <= '0;
      rsp_q <= '0;
    end else begin
      if (fetch) cur_q <= cur_word;
      if (accept)                rsp_q <= '0;
      else if (fetch && !q_wr)   rsp_q <= rd_ext;
    end
  end

  assign core_rd_o = fetch & (region == RG_CORE);
  assign dma_rd_o  = fetch & (region == RG_DMA);
  assign bac_rd_o  = fetch & (region == RG_BAC);
  assign core_wr_o = store & (region == RG_CORE);
  assign dma_wr_o  = store & (region == RG_DMA);
  assign bac_wr_o  = store & (region == RG_BAC);

  assign core_wdata_o = merged;
  assign dma_wdata_o  = merged;
  assign bac_wdata_o  = merged;

  assign rsp_valid_o = done;
  assign rsp_rdata_o = rsp_q;

endmodule

// File: rtl/io_window_adapter_chk.sv
module io_window_adapter_chk #(
  parameter int unsigned CIW = 4,
  parameter int unsigned DIW = 3
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           req_valid_i,
  input logic           req_ready_o,
  input logic           rsp_valid_o,
  input logic           core_rd_o,
  input logic           core_wr_o,
  input logic [CIW-1:0] core_idx_o,
  input logic           dma_rd_o,
  input logic           dma_wr_o,
  input logic [DIW-1:0] dma_idx_o,
  input logic           bac_rd_o,
  input logic           bac_wr_o
);
  logic any_strobe;
  assign any_strobe = core_rd_o | core_wr_o | dma_rd_o | dma_wr_o | bac_rd_o | bac_wr_o;

  assert_one_strobe_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({core_rd_o, core_wr_o, dma_rd_o, dma_wr_o, bac_rd_o, bac_wr_o}));

  assert_busy_strobe_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_strobe |-> !req_ready_o);

  assert_accept_busy_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> !req_ready_o);

  assert_rsp_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> (req_ready_o && !rsp_valid_o));

  assert_rmw_core_idx_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(core_rd_o) && core_wr_o) |-> (core_idx_o == $past(core_idx_o)));

  assert_rmw_dma_idx_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(dma_rd_o) && dma_wr_o) |-> (dma_idx_o == $past(dma_idx_o)));

  assert_rmw_bac_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(bac_rd_o) |-> (bac_wr_o || rsp_valid_o));

endmodule

bind io_window_adapter io_window_adapter_chk #(.CIW(CIW), .DIW(DIW)) u_chk (.*);

// File: tb/sim_io_window_adapter.sv
module sim_io_window_adapter;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [6:0]  req_addr = '0;
  logic [1:0]  req_size = '0;
  logic [31:0] req_wdata = '0;
  logic        req_ready, rsp_valid;
  logic [31:0] rsp_rdata;
  logic        core_rd, core_wr, dma_rd, dma_wr, bac_rd, bac_wr;
  logic [3:0]  core_idx;
  logic [2:0]  dma_idx;
  logic [31:0] core_wd, dma_wd, bac_wd;
  logic [31:0] core_mem [16];
  logic [31:0] dma_mem [8];
  logic [31:0] bac_reg;
  logic [31:0] exp_core [16];
  logic [31:0] exp_dma [8];
  logic [31:0] exp_bac;
  int rd_cnt = 0, wr_cnt = 0;
  int total = 0, fails = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  io_window_adapter u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_write_i(req_write),
    .req_addr_i(req_addr), .req_size_i(req_size), .req_wdata_i(req_wdata),
    .rsp_valid_o(rsp_valid), .rsp_rdata_o(rsp_rdata),
    .core_rd_o(core_rd), .core_wr_o(core_wr), .core_idx_o(core_idx),
    .core_wdata_o(core_wd), .core_rdata_i(core_mem[core_idx]),
    .dma_rd_o(dma_rd), .dma_wr_o(dma_wr), .dma_idx_o(dma_idx),
    .dma_wdata_o(dma_wd), .dma_rdata_i(dma_mem[dma_idx]),
    .bac_rd_o(bac_rd), .bac_wr_o(bac_wr), .bac_wdata_o(bac_wd), .bac_rdata_i(bac_reg)
  );

  function automatic logic [31:0] seed(int r, int i);
    return {8'(r*16 + i), 8'(~i), 8'(i*3 + r + 5), 8'(8'hA0 + i)};
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 16; i++) core_mem[i] <= seed(1, i);
      for (int i = 0; i < 8; i++)  dma_mem[i]  <= seed(2, i);
      bac_reg <= seed(3, 0);
    end else begin
      if (core_wr) core_mem[core_idx] <= core_wd;
      if (dma_wr)  dma_mem[dma_idx]   <= dma_wd;
      if (bac_wr)  bac_reg            <= bac_wd;
    end
    rd_cnt <= rd_cnt + int'(core_rd) + int'(dma_rd) + int'(bac_rd);
    wr_cnt <= wr_cnt + int'(core_wr) + int'(dma_wr) + int'(bac_wr);
  end

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // region per R1..R4: 0 none, 1 core, 2 engine, 3 control
  function automatic int region_of(int a);
    int w = a & ~3;
    if (w < 'h40) return 1;
    if (w < 'h60) return 2;
    if (w == 'h70) return 3;
    return 0;
  endfunction

  function automatic logic [31:0] ref_word(int a);
    int w = a & ~3;
    case (region_of(a))
      1: return exp_core[w >> 2];
      2: return exp_dma[(w - 'h40) >> 2];
      3: return exp_bac;
      default: return 32'h0;
    endcase
  endfunction

  function automatic int nbytes(int sz);
    return (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
  endfunction

  task automatic txn(bit wr, int a, int sz, logic [31:0] wd,
                     output logic [31:0] rdata, output int nrd, output int nwr);
    int r0, w0, guard;
    @(negedge clk);
    r0 = rd_cnt; w0 = wr_cnt;
    req_valid = 1'b1; req_write = wr; req_addr = 7'(a);
    req_size = 2'(sz); req_wdata = wd;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0; req_write = ~wr; req_addr = ~7'(a); req_wdata = ~wd; // R8 scramble
    guard = 0;
    while (!rsp_valid && guard < 20) begin
      @(negedge clk);
      guard++;
    end
    check(guard < 20, "R8 response arrives", 32'(guard), 32'd20);
    rdata = rsp_rdata;
    nrd = rd_cnt - r0;
    nwr = wr_cnt - w0;
  endtask

  initial begin
    logic [31:0] rd, exp, old, wd;
    int nrd, nwr, reg_n, off, nb;
    bit same;
    for (int i = 0; i < 16; i++) exp_core[i] = seed(1, i);
    for (int i = 0; i < 8; i++)  exp_dma[i]  = seed(2, i);
    exp_bac = seed(3, 0);

    repeat (3) @(posedge clk);
    @(negedge clk);
    check(req_ready == 1'b1, "R9 ready in reset", 32'(req_ready), 32'd1);
    check(rsp_valid == 1'b0, "R9 rsp low in reset", 32'(rsp_valid), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check({core_rd, core_wr, dma_rd, dma_wr, bac_rd, bac_wr} == 6'b0, "R9 strobes idle",
          32'({core_rd, core_wr, dma_rd, dma_wr, bac_rd, bac_wr}), 32'd0);
    check(req_ready == 1'b1, "R9 ready after reset", 32'(req_ready), 32'd1);

    // read sweep: R1 R2 R3 R4 R7
    for (int a = 0; a < 128; a++) begin
      for (int sz = 0; sz < 3; sz++) begin
        txn(1'b0, a, sz, 32'h0, rd, nrd, nwr);
        reg_n = region_of(a);
        off = a & 3; nb = nbytes(sz);
        exp = ref_word(a) >> (8 * off);
        if (nb < 4) exp = exp & ((32'h1 << (8 * nb)) - 1);
        check(rd === exp, $sformatf("R7 read a=%0h sz=%0d region R%0d", a, sz, reg_n == 0 ? 4 : reg_n),
              rd, exp);
        check(nrd == (reg_n != 0 ? 1 : 0) && nwr == 0,
              $sformatf("R7 R4 read strobes a=%0h", a), 32'(nrd * 16 + nwr),
              32'(reg_n != 0 ? 16 : 0));
      end
    end

    // write sweep: R1 R2 R3 R4 R5 R6
    for (int a = 0; a < 128; a++) begin
      for (int sz = 0; sz < 4; sz++) begin
        wd = 32'h5C3A_9E17 ^ (32'(a) * 32'h0101_0203) ^ (32'(sz) << 28);
        txn(1'b1, a, sz, wd, rd, nrd, nwr);
        reg_n = region_of(a);
        off = a & 3; nb = nbytes(sz);
        old = ref_word(a);
        exp = old;
        for (int k = 0; k < 4; k++)
          if (k >= off && k < off + nb) exp[8*k +: 8] = wd[8*(k-off) +: 8];
        case (reg_n)
          1: exp_core[(a & ~3) >> 2] = exp;
          2: exp_dma[((a & ~3) - 'h40) >> 2] = exp;
          3: exp_bac = exp;
          default: ;
        endcase
        check(rd == 32'h0, "R8 write response data", rd, 32'h0);
        if (reg_n == 0)
          check(nrd == 0 && nwr == 0, $sformatf("R4 unmapped write a=%0h", a),
                32'(nrd * 16 + nwr), 32'd0);
        else if (sz >= 2 && off == 0)
          check(nrd == 0 && nwr == 1, $sformatf("R5 direct store a=%0h", a),
                32'(nrd * 16 + nwr), 32'd1);
        else
          check(nrd == 1 && nwr == 1, $sformatf("R6 rmw strobes a=%0h sz=%0d", a, sz),
                32'(nrd * 16 + nwr), 32'd17);
        same = 1;
        for (int i = 0; i < 16; i++) if (core_mem[i] !== exp_core[i]) same = 0;
        for (int i = 0; i < 8; i++)  if (dma_mem[i]  !== exp_dma[i])  same = 0;
        if (bac_reg !== exp_bac) same = 0;
        check(same, $sformatf("R6 R5 R1 R2 R3 merged state a=%0h sz=%0d", a, sz),
              {24'h0, 1'b0, 7'(a)}, {24'h0, 1'b0, 7'(a)});
      end
    end

    // full readback of control word through its last byte: R3
    txn(1'b0, 'h73, 0, 32'h0, rd, nrd, nwr);
    check(rd == {24'h0, exp_bac[31:24]}, "R3 top byte of control", rd, {24'h0, exp_bac[31:24]});

    finished = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++;
      fails++;
      $display("FAIL watchdog R8 actual=%h expected=%h", 32'd0, 32'd1);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

endmodule